// File: doc/BRIEF.md
# Prescaled 16-bit Reload/Compare Timer

This block is a 16-bit up-counter driven by a programmable clock prescaler. It runs in one of two modes, chosen by a dedicated input. In auto-reload mode, a 16-bit reload/compare register can be loaded back into the counter. The load happens either when the counter wraps or when a chosen capture channel fires. In compare mode, the counter is checked against the same register, and a match raises a sticky flag.

Three capture event inputs copy the running count into the reload/compare register. In auto-reload mode, a capture can also zero the counter. A compare match can zero the counter too, which turns the timer into a periodic tick source with a programmable period.

Software controls the block through a byte-wide write port. It reaches a mode byte, the two counter bytes, the two register bytes and a flag-clear location.

Top module: `ptimer16`

## Requirements
- R1: After reset, the following are all zero: counter, register, overflow flag, match flag, capture flag and mode byte. Because the mode byte is zero, the divider is 1 and reload is off, so with `run` high the counter advances once per clock.
- R2: The mode byte, written at address 0, has these fields: bit 7 is reload enable, bits 6:4 are the divider code, bit 3 is capture-clear, bit 2 is compare-clear, and bits 1:0 are the reload trigger. Divider codes 0 to 7 give 1, 4, 16, 32, 64, 128, 256 and 512 clocks per increment. A tick occurs D clocks after the divider restarts, where D is the selected divide ratio. The divider restarts whenever the mode byte is written or `run` is low.
- R3: While `run` is low, the counter does not change unless it is written or a capture channel is serviced.
- R4: A tick at count FFFFh sets the overflow flag. If auto-reload mode, reload enable and trigger code 00 all apply, that tick loads the register into the counter. Otherwise the counter wraps to 0000h.
- R5: With reload enable clear, no reload ever happens: an overflow wraps to 0000h, and a capture on the trigger channel acts as a plain capture.
- R6: Consider auto-reload mode with reload enable set and trigger code 01, 10 or 11, which select channels 0, 1 and 2. A serviced event on the selected channel loads the register into the counter, leaves the register unchanged, and sets the capture flag.
- R7: Any other serviced capture event does three things: it copies the counter into the register, sets the capture flag, and drops that cycle's increment. In auto-reload mode with capture-clear set, the event also forces the counter to 0000h.
- R8: In compare mode, capture-clear has no effect, and a capture leaves the counter value in place.
- R9: In compare mode, a tick taken while the counter equals the register sets the match flag. If compare-clear is set, that tick forces the counter to 0000h. If compare-clear is clear, counting continues. In auto-reload mode, no match flag is raised and compare-clear has no effect.
- R10: Capture events are serviced one channel per clock, lowest channel first. An event that is not serviced stays pending until its turn.
- R11: The write addresses are: 1 for the counter low byte, 2 for the counter high byte, 3 for the register low byte and 4 for the register high byte. A write replaces the chosen byte and keeps the other byte at its old value. It takes effect at the writing edge and overrides any increment, reload or capture on the same register in that cycle.
- R12: The three flags are sticky. Writing address 5 clears the overflow flag with data bit 0, the match flag with bit 1 and the capture flag with bit 2. If a flag is set in the same cycle as its clear, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Gates counting and holds the prescaler in restart while low |
| mode_cmp | input | 1 | 1 selects compare mode, 0 selects auto-reload mode |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address (0 mode, 1/2 counter bytes, 3/4 register bytes, 5 flag clear) |
| wr_data | input | 8 | Write data |
| cap_evt | input | 3 | Capture event pulses, one per channel |
| count_o | output | 16 | Counter value |
| cmp_o | output | 16 | Reload/compare register value |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_flag | output | 1 | Sticky compare match flag |
| cap_flag | output | 1 | Sticky capture-serviced flag |

## Verification
The bench covers every divider code and checks both the last clock before a tick and the tick itself. An off-by-one prescaler would therefore fail on both sides. It also rewrites the mode byte in the middle of a prescale interval, which catches a divider that does not restart on that write.

All three channels fire together against a reload triggered by channel 0. A wrong service order or a merged service leaves the wrong value in the counter, and repeated flag clears expose a dropped pending event. Further cases check that a byte write beats an increment and a capture in the same cycle, that compare-clear yields a period of register-plus-one ticks, and that the clear bits stay inert in the wrong mode.

// File: rtl/ptimer16_pkg.sv
package ptimer16_pkg;

    localparam int CNT_W = 16;
    localparam int NCAP  = 3;

    typedef enum logic [2:0] {
        A_MODE   = 3'd0,
        A_CNT_LO = 3'd1,
        A_CNT_HI = 3'd2,
        A_CMP_LO = 3'd3,
        A_CMP_HI = 3'd4,
        A_FLAGS  = 3'd5
    } addr_e;

    // field positions are fixed by the mode byte layout
    typedef struct packed {
        logic       ld_en;
        logic [2:0] div;
        logic       cap_clr;
        logic       cmp_clr;
        logic [1:0] trig;
    } mode_t;

    typedef struct packed {
        mode_t             mode;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  cmp;
        logic [NCAP-1:0]   pend;
        logic              ovf;
        logic              mat;
        logic              cap;
    } tstate_t;

endpackage

// File: rtl/ptimer16_presc.sv
module ptimer16_presc #(
    parameter int PRE_W = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] div_code,
    output logic       tick
);
    logic [PRE_W-1:0] pcnt_d, pcnt_q;
    logic [PRE_W-1:0] term;

    // terminal count = ratio - 1, ratio = 1,4,16,32,...,512
    function automatic logic [PRE_W-1:0] term_of(input logic [2:0] code);
        logic [PRE_W:0] full;
        int unsigned    sh;
        case (code)
            3'd0:    sh = 0;
            3'd1:    sh = 2;
            3'd2:    sh = 4;
            default: sh = 32'(code) + 2;
        endcase
        full = ({{PRE_W{1'b0}}, 1'b1} << sh) - 1'b1;
        return full[PRE_W-1:0];
    endfunction

    always_comb begin
        term = term_of(div_code);
        tick = run && !restart && (pcnt_q == term);
        if (!run || restart || tick)
            pcnt_d = '0;
        else
            pcnt_d = pcnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end
endmodule

// File: rtl/ptimer16_capsel.sv
module ptimer16_capsel #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_pri
        assign grant[i]  = req[i] && !seen[i];
        assign seen[i+1] = seen[i] || req[i];
    end
endmodule

// File: rtl/ptimer16.sv
module ptimer16
    import ptimer16_pkg::*;
#(
    parameter int PRE_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             mode_cmp,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [NCAP-1:0]  cap_evt,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             ovf_flag,
    output logic             match_flag,
    output logic             cap_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    tstate_t          s_d, s_q;
    logic             tick;
    logic             mode_wr;
    logic [NCAP-1:0]  cap_req;
    logic [NCAP-1:0]  cap_grant;
    logic [NCAP-1:0]  pend_now;
    logic             evt_any, evt_reload, evt_cap;
    logic             reload_mode, trig_hit, at_max, at_cmp;

    assign mode_wr  = wr_en && (wr_addr == A_MODE);
    assign cap_req  = s_q.pend | cap_evt;
    assign pend_now = s_q.pend;

    ptimer16_presc #(.PRE_W(PRE_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .restart  (mode_wr),
        .div_code (s_q.mode.div),
        .tick     (tick)
    );

    ptimer16_capsel #(.N(NCAP)) u_capsel (
        .req   (cap_req),
        .grant (cap_grant)
    );

    always_comb begin
        s_d         = s_q;
        reload_mode = !mode_cmp;
        at_max      = (s_q.cnt == CNT_MAX);
        at_cmp      = (s_q.cnt == s_q.cmp);
        trig_hit    = ((s_q.mode.trig == 2'd1) && cap_grant[0]) ||
                      ((s_q.mode.trig == 2'd2) && cap_grant[1]) ||
                      ((s_q.mode.trig == 2'd3) && cap_grant[2]);
        evt_any     = |cap_grant;
        evt_reload  = evt_any && reload_mode && s_q.mode.ld_en && trig_hit;
        evt_cap     = evt_any && !evt_reload;

        s_d.pend = cap_req & ~cap_grant;

        // counter and register update: events first, then ticks
        if (evt_reload) begin
            s_d.cnt = s_q.cmp;
        end else if (evt_cap) begin
            s_d.cmp = s_q.cnt;
            if (reload_mode && s_q.mode.cap_clr)
                s_d.cnt = '0;
        end else if (tick) begin
            if (mode_cmp && s_q.mode.cmp_clr && at_cmp)
                s_d.cnt = '0;
            else if (at_max)
                s_d.cnt = (reload_mode && s_q.mode.ld_en && s_q.mode.trig == 2'd0)
                          ? s_q.cmp : '0;
            else
                s_d.cnt = s_q.cnt + 1'b1;
        end

        // flags: clear by write, set wins
        if (wr_en && wr_addr == A_FLAGS) begin
            if (wr_data[0]) s_d.ovf = 1'b0;
            if (wr_data[1]) s_d.mat = 1'b0;
            if (wr_data[2]) s_d.cap = 1'b0;
        end
        if (evt_any)                               s_d.cap = 1'b1;
        if (tick && !evt_any && at_max)            s_d.ovf = 1'b1;
        if (tick && !evt_any && mode_cmp && at_cmp) s_d.mat = 1'b1;

        // software byte writes override the whole update of that register
        if (wr_en) begin
            case (wr_addr)
                A_MODE:   s_d.mode = mode_t'(wr_data);
                A_CNT_LO: s_d.cnt  = {s_q.cnt[CNT_W-1:8], wr_data};
                A_CNT_HI: s_d.cnt  = {wr_data, s_q.cnt[7:0]};
                A_CMP_LO: s_d.cmp  = {s_q.cmp[CNT_W-1:8], wr_data};
                A_CMP_HI: s_d.cmp  = {wr_data, s_q.cmp[7:0]};
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o    = s_q.cnt;
    assign cmp_o      = s_q.cmp;
    assign ovf_flag   = s_q.ovf;
    assign match_flag = s_q.mat;
    assign cap_flag   = s_q.cap;
endmodule

// File: rtl/ptimer16_chk.sv
module ptimer16_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        mode_cmp,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [7:0]  wr_data,
    input logic [2:0]  cap_evt,
    input logic [15:0] count_o,
    input logic        ovf_flag,
    input logic        match_flag,
    input logic [2:0]  grant,
    input logic [2:0]  pend
);
    // R3
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en && cap_evt == 3'b000 && pend == 3'b000) |=> $stable(count_o));

    // R4
    ovf_from_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(count_o) == 16'hFFFF));

    // R9
    match_only_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> $past(mode_cmp));

    // R10
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R11
    cnt_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd1) |=> (count_o[7:0] == $past(wr_data)));

    // R12
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(wr_en && wr_addr == 3'd5 && wr_data[0])) |=> ovf_flag);

    // R12
    match_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !(wr_en && wr_addr == 3'd5 && wr_data[1])) |=> match_flag);
endmodule

bind ptimer16 ptimer16_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .mode_cmp   (mode_cmp),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cap_evt    (cap_evt),
    .count_o    (count_o),
    .ovf_flag   (ovf_flag),
    .match_flag (match_flag),
    .grant      (cap_grant),
    .pend       (pend_now)
);

// File: tb/ptimer16_tb.sv
`timescale 1ns/1ps
module ptimer16_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        mode_cmp = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [2:0]  cap_evt = 3'd0;
    logic [15:0] count_o, cmp_o;
    logic        ovf_flag, match_flag, cap_flag;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    ptimer16 u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .mode_cmp(mode_cmp),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cap_evt(cap_evt),
        .count_o(count_o), .cmp_o(cmp_o), .ovf_flag(ovf_flag),
        .match_flag(match_flag), .cap_flag(cap_flag)
    );

    // behavioural reference model
    int m_cnt = 0, m_cmp = 0, m_pre = 0, m_mode = 0;
    bit [2:0] m_pend = 0;
    bit m_ovf = 0, m_mat = 0, m_cap = 0;

    function automatic int ratio(input int code);
        int r[8] = '{1, 4, 16, 32, 64, 128, 256, 512};
        return r[code];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cmp = 0; m_pre = 0; m_mode = 0; m_pend = 0;
            m_ovf = 0; m_mat = 0; m_cap = 0;
        end else begin
            int cnt_n, cmp_n, pre_n, ch, trig;
            bit restart, tk, ov_s, mt_s, rl, ld, is_rl;
            bit [2:0] req;
            restart = wr_en && wr_addr == 3'd0;
            tk = run && !restart && (m_pre + 1 == ratio((m_mode >> 4) & 7));
            pre_n = (!run || restart || tk) ? 0 : m_pre + 1;
            req = m_pend | cap_evt;
            ch = -1;
            for (int i = 0; i < 3; i++) if (req[i] && ch < 0) ch = i;
            if (ch >= 0) req[ch] = 1'b0;
            rl = !mode_cmp; ld = m_mode[7]; trig = m_mode & 3;
            is_rl = (ch >= 0) && rl && ld && (trig == ch + 1);
            cnt_n = m_cnt; cmp_n = m_cmp; ov_s = 0; mt_s = 0;
            if (ch >= 0) begin
                if (is_rl) cnt_n = m_cmp;
                else begin
                    cmp_n = m_cnt;
                    if (rl && m_mode[3]) cnt_n = 0;
                end
            end else if (tk) begin
                ov_s = (m_cnt == 65535);
                mt_s = mode_cmp && (m_cnt == m_cmp);
                if (mode_cmp && m_mode[2] && m_cnt == m_cmp) cnt_n = 0;
                else if (m_cnt == 65535) cnt_n = (rl && ld && trig == 0) ? m_cmp : 0;
                else cnt_n = m_cnt + 1;
            end
            if (wr_en && wr_addr == 3'd5) begin
                if (wr_data[0]) m_ovf = 0;
                if (wr_data[1]) m_mat = 0;
                if (wr_data[2]) m_cap = 0;
            end
            if (ch >= 0) m_cap = 1;
            if (ov_s) m_ovf = 1;
            if (mt_s) m_mat = 1;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_mode = wr_data;
                    3'd1: cnt_n = (m_cnt & 16'hFF00) | wr_data;
                    3'd2: cnt_n = (m_cnt & 16'h00FF) | (int'(wr_data) << 8);
                    3'd3: cmp_n = (m_cmp & 16'hFF00) | wr_data;
                    3'd4: cmp_n = (m_cmp & 16'h00FF) | (int'(wr_data) << 8);
                    default: ;
                endcase
            end
            m_cnt = cnt_n; m_cmp = cmp_n; m_pre = pre_n; m_pend = req;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) begin
            chk(cur_req, "model count", int'(count_o), m_cnt);
            chk(cur_req, "model cmp", int'(cmp_o), m_cmp);
            chk(cur_req, "model flags", int'({ovf_flag, match_flag, cap_flag}),
                int'({m_ovf, m_mat, m_cap}));
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int e);
        cap_evt = 3'(e);
        cyc();
        cap_evt = 3'd0;
    endtask

    task automatic set_cnt(input int v);
        wr(1, v & 255); wr(2, (v >> 8) & 255);
    endtask

    task automatic set_cmp(input int v);
        wr(3, v & 255); wr(4, (v >> 8) & 255);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int c;
        cycles(3);
        @(negedge clk); rst_n = 1'b1;
        cur_req = "R1";
        chk("R1", "reset count", int'(count_o), 0);
        chk("R1", "reset cmp", int'(cmp_o), 0);
        chk("R1", "reset flags", int'({ovf_flag, match_flag, cap_flag}), 0);
        run = 1'b1; cycles(3); run = 1'b0;
        chk("R1", "divide-by-1 after reset", int'(count_o), 3);
        cyc();

        // R2 every divider code
        cur_req = "R2";
        for (int code = 0; code < 8; code++) begin
            wr(0, code << 4); set_cnt(0);
            run = 1'b1;
            cycles(2 * ratio(code) - 1);
            chk("R2", $sformatf("code %0d before 2nd tick", code), int'(count_o), 1);
            cyc();
            chk("R2", $sformatf("code %0d 2nd tick", code), int'(count_o), 2);
            run = 1'b0; cyc();
        end
        // R2 restart on mode write
        wr(0, 8'h10); set_cnt(0); run = 1'b1;
        cycles(3); wr(0, 8'h10); cycles(3);
        chk("R2", "restart holds count", int'(count_o), 0);
        cyc();
        chk("R2", "tick after restart", int'(count_o), 1);
        run = 1'b0; cyc();

        // R3 hold while stopped
        cur_req = "R3";
        c = int'(count_o); cycles(5);
        chk("R3", "stopped count", int'(count_o), c);

        // R4 overflow reload
        cur_req = "R4";
        wr(0, 8'h80); set_cnt(16'hFFFE); set_cmp(16'h1234);
        run = 1'b1; cycles(2); run = 1'b0;
        chk("R4", "reload on overflow", int'(count_o), 16'h1234);
        chk("R4", "overflow flag", int'(ovf_flag), 1);
        cur_req = "R12"; cycles(2);
        chk("R12", "ovf sticky", int'(ovf_flag), 1);
        wr(5, 1);
        chk("R12", "ovf cleared", int'(ovf_flag), 0);

        // R5 reload disabled
        cur_req = "R5";
        wr(0, 8'h00); set_cnt(16'hFFFF);
        run = 1'b1; cyc(); run = 1'b0;
        chk("R5", "wrap to zero", int'(count_o), 0);
        chk("R5", "ovf on wrap", int'(ovf_flag), 1);
        wr(5, 7);

        // R6 capture-triggered reload on channel 1
        cur_req = "R6";
        wr(0, 8'h82); set_cnt(16'h0100); set_cmp(16'h4000);
        pulse(3'b010);
        chk("R6", "reload from ch1", int'(count_o), 16'h4000);
        chk("R6", "register kept", int'(cmp_o), 16'h4000);
        chk("R6", "cap flag", int'(cap_flag), 1);
        cur_req = "R5";
        wr(0, 8'h02); set_cnt(16'h0100);
        pulse(3'b010);
        chk("R5", "no reload when disabled", int'(count_o), 16'h0100);
        chk("R5", "plain capture", int'(cmp_o), 16'h0100);
        wr(5, 7);

        // R7 capture, increment dropped, then capture-clear
        cur_req = "R7";
        wr(0, 8'h82); set_cnt(16'h0055); set_cmp(16'h4000);
        run = 1'b1; pulse(3'b001); run = 1'b0;
        chk("R7", "captured value", int'(cmp_o), 16'h0055);
        chk("R7", "increment dropped", int'(count_o), 16'h0055);
        wr(0, 8'h88);
        pulse(3'b100);
        chk("R7", "capture before clear", int'(cmp_o), 16'h0055);
        chk("R7", "counter cleared", int'(count_o), 0);

        // R8 capture-clear ignored in compare mode
        cur_req = "R8";
        mode_cmp = 1'b1;
        wr(0, 8'h08); set_cnt(16'h0077);
        pulse(3'b001);
        chk("R8", "compare-mode capture", int'(cmp_o), 16'h0077);
        chk("R8", "no clear", int'(count_o), 16'h0077);
        wr(5, 7);

        // R9 compare match
        cur_req = "R9";
        wr(0, 8'h04); set_cmp(5); set_cnt(0);
        run = 1'b1; cycles(5);
        chk("R9", "reach compare", int'(count_o), 5);
        chk("R9", "no match yet", int'(match_flag), 0);
        cyc(); run = 1'b0;
        chk("R9", "cleared on match", int'(count_o), 0);
        chk("R9", "match flag", int'(match_flag), 1);
        wr(5, 2);
        wr(0, 8'h00); set_cnt(0);
        run = 1'b1; cycles(6); run = 1'b0;
        chk("R9", "count past match", int'(count_o), 6);
        chk("R9", "match without clear", int'(match_flag), 1);
        wr(5, 7);
        mode_cmp = 1'b0;
        wr(0, 8'h04); set_cnt(0);
        run = 1'b1; cycles(7); run = 1'b0;
        chk("R9", "reload mode ignores compare", int'(count_o), 7);
        chk("R9", "no match in reload mode", int'(match_flag), 0);

        // R10 channel ordering
        cur_req = "R10";
        wr(0, 8'h81); set_cnt(16'h00AA); set_cmp(16'h00BB); wr(5, 7);
        pulse(3'b111);
        chk("R10", "ch0 first reloads", int'(count_o), 16'h00BB);
        wr(5, 4);
        chk("R10", "ch1 pending serviced", int'(cap_flag), 1);
        wr(5, 4);
        chk("R10", "ch2 pending serviced", int'(cap_flag), 1);
        cur_req = "R12";
        wr(5, 4);
        chk("R12", "clear with nothing pending", int'(cap_flag), 0);

        // R11 write overrides
        cur_req = "R11";
        wr(0, 8'h00); set_cnt(16'h0203);
        run = 1'b1; wr(1, 8'h10);
        chk("R11", "write beats increment", int'(count_o), 16'h0210);
        cyc(); run = 1'b0;
        chk("R11", "counting resumes", int'(count_o), 16'h0211);
        set_cmp(16'h7700);
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h99; cap_evt = 3'b001;
        cyc();
        wr_en = 1'b0; cap_evt = 3'd0;
        chk("R11", "write beats capture", int'(cmp_o), 16'h7799);
        chk("R11", "capture still flagged", int'(cap_flag), 1);
        cycles(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule